// File: doc/BRIEF.md
# I2C Write Packet Receiver

This block is an I2C target that only accepts write transfers. It oversamples the open-drain SCL and SDA lines with the system clock and recognises bus START and STOP conditions. It compares each address byte with a 7-bit address taken from an input port. After a matching write address it stores the data bytes that follow into one of two packet banks.

A packet closes when the bus master issues either a STOP or a repeated START. The closed bank is then presented to the consumer with its byte count, and reception moves to the other bank. The consumer reads the bytes through an index/data port. It returns the bank by pulsing the ready input while the valid output is high. The block never drives SDA high. It only pulls the line low through an output enable for its ACK bits.

Top module: `i2c_pkt_rx`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. An address byte whose upper 7 bits equal `addr_i` and whose bit 0 (direction) is 0 is ACKed, meaning SDA is pulled low during the ninth clock.
- R2: An address byte that does not match, or that carries direction bit 1, gets no ACK. All bytes after it are neither ACKed nor stored, up to the next START.
- R3: Each data byte is ACKed while the current bank holds fewer than DEPTH bytes (default 16). Once the bank is full, every further byte of the transfer is NAKed and discarded.
- R4: A STOP or a repeated START after at least one stored byte ends the packet. `pkt_valid_o` then rises with `pkt_len_o` equal to the number of stored bytes.
- R5: A transfer whose address was ACKed but which stored no data byte delivers no packet.
- R6: After a repeated START that names another address, no byte is captured, including that address byte.
- R7: A STOP or START inside a byte drops the partial byte, releases SDA and returns to address wait. Bytes already completed still form a packet.
- R8: While both banks hold undelivered packets, the address byte of a new transfer is NAKed. That transfer stores nothing.
- R9: `rd_data_o` shows byte `rd_idx_i` of the presented packet, with byte 0 being the first byte received. A one-cycle `pkt_ready_i` pulse while `pkt_valid_o` is high releases the packet. Packets are presented in arrival order.
- R10: `sda_oe_o` is 0 after reset. It changes only while SCL is low: it is set after the falling SCL edge that ends bit 8 and cleared after the falling edge that ends the ninth clock. Data is taken MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Own target address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| pkt_valid_o | output | 1 | A finished packet is presented |
| pkt_len_o | output | LW | Byte count of the presented packet |
| pkt_ready_i | input | 1 | Release pulse for the presented packet |
| rd_idx_i | input | IW | Byte index into the presented packet |
| rd_data_o | output | 8 | Byte at `rd_idx_i` |

## Verification
The assertions assume that the master changes SDA only while SCL is low, apart from START and STOP. They also assume that SCL stays low for several system clocks, so that the output enable always toggles inside an SCL-low phase. They further assume that the consumer pulses ready only while a packet is presented. The bench master holds each SCL quarter period for five system clocks and moves SDA only in the low quarters, except when it forms START and STOP. It pulses ready for exactly one cycle, and only after checking valid.

// File: rtl/i2c_pkt_rx_pkg.sv
package i2c_pkt_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK,
    ST_SKIP
  } rx_state_e;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw;
  logic [1:0] lvl;
  logic [1:0] lvl_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic s1, s2, s3;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
        s3 <= 1'b1;
      end else begin
        s1 <= raw[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl[g]   = s2;
    assign lvl_q[g] = s3;
  end

  assign sda_o      = lvl[1];
  assign scl_rise_o = lvl[0] & ~lvl_q[0];
  assign scl_fall_o = ~lvl[0] & lvl_q[0];
  assign start_o    = lvl[0] & lvl_q[0] & lvl_q[1] & ~lvl[1];
  assign stop_o     = lvl[0] & lvl_q[0] & ~lvl_q[1] & lvl[1];
endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
  import i2c_pkt_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [6:0] addr_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       wr_full_i,
  input  logic       wr_busy_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic       pkt_end_o
);
  rx_state_e  state_q;
  logic       is_addr_q;
  logic       sel_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] shreg_q;
  logic       oe_q;
  logic       byte_done;
  logic       addr_ok;

  assign byte_done = (state_q == ST_SHIFT) && scl_fall_i && (bit_cnt_q == 4'd8);
  assign addr_ok   = (shreg_q[7:1] == addr_i) && !shreg_q[0] && !wr_busy_i;
  assign wr_en_o   = byte_done && !is_addr_q && sel_q && !wr_full_i && !start_i && !stop_i;
  assign wr_data_o = shreg_q;
  assign pkt_end_o = (start_i || stop_i) && sel_q;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      is_addr_q <= 1'b1;
      sel_q     <= 1'b0;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      oe_q      <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_SHIFT;
      is_addr_q <= 1'b1;
      sel_q     <= 1'b0;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_SHIFT: begin
          if (scl_rise_i && bit_cnt_q < 4'd8) begin
            shreg_q   <= {shreg_q[6:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            state_q <= ST_ACK;
            if (is_addr_q) begin
              oe_q  <= addr_ok;
              sel_q <= addr_ok;
            end else begin
              oe_q <= !wr_full_i;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
            is_addr_q <= 1'b0;
            state_q   <= sel_q ? ST_SHIFT : ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_pkt_dbuf.sv
module i2c_pkt_dbuf #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IW    = $clog2(DEPTH),
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [7:0]    wr_data_i,
  input  logic          pkt_end_i,
  input  logic          pkt_ready_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic          wr_full_o,
  output logic          wr_busy_o,
  output logic [LW-1:0] wr_cnt_o,
  output logic          pkt_valid_o,
  output logic [LW-1:0] pkt_len_o,
  output logic [7:0]    rd_data_o
);
  import i2c_pkt_rx_pkg::NUM_BANKS;

  logic [LW-1:0] cnt_q;
  logic          wr_sel_q;
  logic          rd_sel_q;
  logic [1:0]    busy_q;
  logic [LW-1:0] len_q [NUM_BANKS];
  logic [7:0]    bank_rd [NUM_BANKS];
  logic          release_pkt;

  assign release_pkt = pkt_ready_i && busy_q[rd_sel_q];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_sel_q == 1'(b)))
        mem[cnt_q[IW-1:0]] <= wr_data_i;
    end
    assign bank_rd[b] = mem[rd_idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      wr_sel_q <= 1'b0;
      rd_sel_q <= 1'b0;
      busy_q   <= '0;
      len_q[0] <= '0;
      len_q[1] <= '0;
    end else begin
      if (pkt_end_i && cnt_q != '0) begin
        busy_q[wr_sel_q] <= 1'b1;
        len_q[wr_sel_q]  <= cnt_q;
        wr_sel_q         <= ~wr_sel_q;
        cnt_q            <= '0;
      end else if (wr_en_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (release_pkt) begin
        busy_q[rd_sel_q] <= 1'b0;
        rd_sel_q         <= ~rd_sel_q;
      end
    end
  end

  assign wr_full_o   = (cnt_q == LW'(DEPTH));
  assign wr_busy_o   = busy_q[wr_sel_q];
  assign wr_cnt_o    = cnt_q;
  assign pkt_valid_o = busy_q[rd_sel_q];
  assign pkt_len_o   = len_q[rd_sel_q];
  assign rd_data_o   = bank_rd[rd_sel_q];
endmodule

// File: rtl/i2c_pkt_rx.sv
module i2c_pkt_rx #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [6:0]    addr_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          pkt_valid_o,
  output logic [LW-1:0] pkt_len_o,
  input  logic          pkt_ready_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [7:0]    rd_data_o
);
  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en, wr_full, wr_busy, pkt_end;
  logic [7:0]    wr_data;
  logic [LW-1:0] wr_cnt;

  i2c_line_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_rx_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .wr_full_i  (wr_full),
    .wr_busy_i  (wr_busy),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .pkt_end_o  (pkt_end)
  );

  i2c_pkt_dbuf #(.DEPTH(DEPTH), .IW(IW), .LW(LW)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .pkt_end_i   (pkt_end),
    .pkt_ready_i (pkt_ready_i),
    .rd_idx_i    (rd_idx_i),
    .wr_full_o   (wr_full),
    .wr_busy_o   (wr_busy),
    .wr_cnt_o    (wr_cnt),
    .pkt_valid_o (pkt_valid_o),
    .pkt_len_o   (pkt_len_o),
    .rd_data_o   (rd_data_o)
  );
endmodule

// File: rtl/i2c_pkt_rx_chk.sv
module i2c_pkt_rx_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic          pkt_valid_o,
  input logic          pkt_ready_i,
  input logic [LW-1:0] pkt_len_o,
  input logic [LW-1:0] wr_cnt,
  input logic          stop_det
);
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i); // R10

  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_det) |-> !sda_oe_o); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt <= LW'(DEPTH)); // R3

  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> (pkt_len_o != '0) && (pkt_len_o <= LW'(DEPTH))); // R5

  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && !pkt_ready_i |=> pkt_valid_o && $stable(pkt_len_o)); // R4
endmodule

bind i2c_pkt_rx i2c_pkt_rx_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .sda_oe_o    (sda_oe_o),
  .pkt_valid_o (pkt_valid_o),
  .pkt_ready_i (pkt_ready_i),
  .pkt_len_o   (pkt_len_o),
  .wr_cnt      (wr_cnt),
  .stop_det    (stop_det)
);

// File: tb/i2c_pkt_rx_test.sv
`timescale 1ns/1ps
module i2c_pkt_rx_test;
  localparam int DEPTH = 16;
  localparam int IW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int Q = 5;
  localparam logic [6:0] OWN = 7'h2A;

  // fields: [23:17] address, [16] direction, [15:8] data byte count, [7:0] expected length
  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    {7'h2A, 1'b0, 8'd3,  8'd3},
    {7'h2A, 1'b0, 8'd16, 8'd16},
    {7'h2A, 1'b0, 8'd19, 8'd16},
    {7'h13, 1'b0, 8'd4,  8'd0},
    {7'h2A, 1'b1, 8'd2,  8'd0},
    {7'h2A, 1'b0, 8'd0,  8'd0},
    {7'h2A, 1'b0, 8'd1,  8'd1}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic pkt_ready_i = 1'b0;
  logic [IW-1:0] rd_idx_i = '0;
  logic sda_oe_o, pkt_valid_o, sda_bus;
  logic [LW-1:0] pkt_len_o;
  logic [7:0] rd_data_o;
  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;
  assign sda_bus = sda_m & ~sda_oe_o;

  i2c_pkt_rx #(.DEPTH(DEPTH)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(OWN), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe_o), .pkt_valid_o(pkt_valid_o), .pkt_len_o(pkt_len_o),
    .pkt_ready_i(pkt_ready_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tq;
    repeat (Q) @(posedge clk_i);
    #2;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tq; scl_m = 1'b1; tq; sda_m = 1'b0; tq; scl_m = 1'b0; tq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tq; scl_m = 1'b1; tq; sda_m = 1'b1; tq; tq;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tq; scl_m = 1'b1; tq; tq; scl_m = 1'b0; tq;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tq; scl_m = 1'b1; tq;
    acked = !sda_bus;
    tq; scl_m = 1'b0; tq;
  endtask

  task automatic expect_pkt(input string tag, input int len, input int seed);
    tq;
    check({tag, " valid"}, int'(pkt_valid_o), 1);
    check({tag, " len"}, int'(pkt_len_o), len);
    for (int i = 0; i < len; i++) begin
      rd_idx_i = IW'(i);
      @(posedge clk_i); #2;
      check({tag, " data"}, int'(rd_data_o), (seed + i) % 256);
    end
    pkt_ready_i = 1'b1;
    @(posedge clk_i); #2;
    pkt_ready_i = 1'b0;
    @(posedge clk_i); #2;
  endtask

  task automatic expect_none(input string tag);
    tq;
    check({tag, " no packet"}, int'(pkt_valid_o), 0);
  endtask

  task automatic addr_txn(input string tag, input logic [6:0] a, input int exp_ack);
    logic ak;
    send_byte({a, 1'b0}, ak);
    check({tag, " addr ack"}, int'(ak), exp_ack);
  endtask

  task automatic data_bytes(input string tag, input int n, input int seed, input int exp_ack);
    logic ak;
    for (int i = 0; i < n; i++) begin
      send_byte(8'((seed + i) % 256), ak);
      check({tag, " data ack"}, int'(ak), exp_ack);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog R1 actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ak;
    repeat (4) @(posedge clk_i);
    #2;
    check("R10 reset oe", int'(sda_oe_o), 0);
    check("R4 reset valid", int'(pkt_valid_o), 0);
    rst_ni = 1'b1;
    tq;

    for (int v = 0; v < NV; v++) begin
      logic [6:0] a;
      logic rw;
      int n, elen, seed, match;
      string tag;
      a = VEC[v][23:17]; rw = VEC[v][16]; n = int'(VEC[v][15:8]); elen = int'(VEC[v][7:0]);
      seed = v * 32 + 7;
      match = (a == OWN && !rw) ? 1 : 0;
      tag = !match ? "R2" : (n == 0 ? "R5" : (n > DEPTH ? "R3" : "R4"));
      bus_start;
      send_byte({a, rw}, ak);
      check(match ? "R1 addr ack" : "R2 addr nak", int'(ak), match);
      for (int i = 0; i < n; i++) begin
        send_byte(8'((seed + i) % 256), ak);
        if (match != 0) check("R3 data ack", int'(ak), (i < DEPTH) ? 1 : 0);
        else check("R2 ignored byte", int'(ak), 0);
      end
      bus_stop;
      if (elen > 0) expect_pkt(tag, elen, seed);
      else expect_none(tag);
    end

    // R6: repeated START to another address
    bus_start; addr_txn("R6", OWN, 1); data_bytes("R6", 2, 100, 1);
    bus_start; addr_txn("R6", 7'h11, 0); data_bytes("R6", 2, 200, 0);
    bus_stop;
    expect_pkt("R6", 2, 100);
    expect_none("R6");

    // R8 / R9: two held packets, third transfer refused, in-order delivery
    bus_start; addr_txn("R4", OWN, 1); data_bytes("R4", 2, 120, 1);
    bus_start; addr_txn("R4", OWN, 1); data_bytes("R4", 3, 130, 1);
    bus_stop;
    bus_start; addr_txn("R8", OWN, 0); data_bytes("R8", 1, 90, 0);
    bus_stop;
    expect_pkt("R9 first", 2, 120);
    expect_pkt("R9 second", 3, 130);
    expect_none("R8");
    bus_start; addr_txn("R8 freed", OWN, 1); data_bytes("R8", 1, 140, 1);
    bus_stop;
    expect_pkt("R8", 1, 140);

    // R7: STOP in the middle of a byte
    bus_start; addr_txn("R7", OWN, 1); data_bytes("R7", 2, 150, 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop;
    check("R7 oe released", int'(sda_oe_o), 0);
    expect_pkt("R7 stop", 2, 150);

    // R7: START in the middle of a byte
    bus_start; addr_txn("R7", OWN, 1); data_bytes("R7", 1, 160, 1);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    bus_start; addr_txn("R7", OWN, 1); data_bytes("R7", 1, 170, 1);
    bus_stop;
    expect_pkt("R7 start a", 1, 160);
    expect_pkt("R7 start b", 1, 170);
    expect_none("R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule